// File: doc/BRIEF.md
# USB Controller Bring-Up Sequencer

This block is a hardware state machine that powers up a dual-role USB controller in a fixed order after a one-cycle start command. It owns the reset lines of the PHY, the host core and the control shim, the reset, ratio select and enable of the controller-clock divider, the PHY power and reference enables, the interface clock enable and the role bit. Software or a boot controller pulses `start_i` once. The sequencer then walks the order with no further help and raises `done_o` when the controller is ready for use.

The divider ratio is picked in hardware. The input clock rate is given in whole MHz. The sequencer scans the ratio table 1, 2, 4, 6, 8, 16, 24, 32 in that order, one entry per cycle, and takes the first ratio whose truncated quotient falls inside a 150 to 300 MHz window. If no ratio fits, the machine parks in an error state with every reset still held. A small I/O stage turns the port-power request into a pin of configurable polarity and turns the overcurrent pin into an active-high flag.

Top module: `usb_bringup_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, the three reset outputs are 1, the divider reset, divider enable, PHY power, spread-spectrum, reference and interface-clock enables are 0, `div_sel_o` is 0, `mode_dev_o` is 1, `done_o`, `err_o` and `pp_pin_o` are 0.
- R2: The start edge is the rising clock edge at which `start_i` is sampled high in idle. The three resets stay asserted, and the divider reset rises 2 edges after the start edge.
- R3: Edge 3+i tests table entry i (code i selects ratio 1,2,4,6,8,16,24,32 for i = 0..7). At the edge of the first entry k where floor(rate/ratio) lies in [150,300], `div_sel_o` takes the code k and `hclk_en_o` rises.
- R4: The divider reset falls at edge 4+k. The HS power, SS power, spread-spectrum and SuperSpeed reference enables all rise at edge 5+k.
- R5: With W = WAIT_CYC, the shim reset falls at edge 6+k+W. The port-power settings are captured at edge 7+k+2W. The core reset falls at edge 8+k+2W. The interface clock enable rises and `mode_dev_o` falls at edge 9+k+3W. The PHY reset falls and `done_o` rises at edge 10+k+3W.
- R6: If no entry fits, `err_o` rises at edge 10. After that all three resets stay 1, the divider reset stays 1, the enables stay 0 and `done_o` stays 0.
- R7: `start_i` has no effect outside idle, whether the sequence is running, done or failed. Only `rst_n` returns the machine to idle.
- R8: Once captured with its enable at 1, `pp_pin_o` equals `pp_req_i` when the polarity bit is 1 and its inverse when it is 0. With the enable at 0, or before capture, `pp_pin_o` is 0 whatever the polarity or request.
- R9: `oc_flag_o` equals `oc_pin_i` when `oc_pol_high_i` is 1 and its inverse when it is 0, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle only |
| rate_mhz_i | input | RATE_W | Input clock rate in whole MHz, held stable while running |
| pp_en_cfg_i | input | 1 | Port-power control enable setting |
| pp_pol_high_i | input | 1 | Port-power pin polarity, 1 = active high |
| pp_req_i | input | 1 | Port-power request from the host core |
| oc_pol_high_i | input | 1 | Overcurrent pin polarity, 1 = active high |
| oc_pin_i | input | 1 | Overcurrent pin from off chip |
| phy_rst_o | output | 1 | PHY reset |
| core_rst_o | output | 1 | Host core reset |
| shim_rst_o | output | 1 | Control shim reset |
| div_rst_o | output | 1 | Controller-clock divider reset |
| div_sel_o | output | 3 | Divider ratio code |
| hclk_en_o | output | 1 | Controller clock enable |
| hs_pwr_o | output | 1 | High-speed PHY power enable |
| ss_pwr_o | output | 1 | SuperSpeed PHY power enable |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ssp_ref_en_o | output | 1 | SuperSpeed reference clock enable |
| ifclk_en_o | output | 1 | Interface clock enable |
| mode_dev_o | output | 1 | Role bit, 0 = host |
| pp_pin_o | output | 1 | Polarity-corrected port-power pin |
| oc_flag_o | output | 1 | Active-high overcurrent flag |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | No legal divider ratio found |

## Verification
The assertions assume that `rate_mhz_i` and the port-power settings stay constant from the start edge until the sequence ends. They also assume that `rst_n` is the only way out of the done and error states. The stimulus changes the rate and settings only while reset is held, and starts every run from a fresh reset. Within that limit it holds `start_i` high for whole runs, so restart attempts in every state are covered. It also picks rates that sit exactly on window edges and rates for which no ratio fits.

// File: rtl/usb_seq_pkg.sv
// Package: shared state encoding and ratio table for the bring-up sequencer.
// Assumes ratio codes 0..NUM_RATIOS-1 are scanned in ascending order.
package usb_seq_pkg;

    localparam int NUM_RATIOS = 8;
    localparam int SEL_W      = $clog2(NUM_RATIOS);

    typedef enum logic [3:0] {
        ST_IDLE, ST_RSTALL, ST_DIVRST, ST_SEARCH, ST_DIVREL, ST_PWR,
        ST_WAIT1, ST_SHIMREL, ST_WAIT2, ST_PPC, ST_COREREL, ST_WAIT3,
        ST_FIN, ST_PHYREL, ST_DONE, ST_ERR
    } seq_state_t;

    // Maps a ratio code to its divide ratio.
    function automatic int unsigned ratio_of(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 16;
            3'd6:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/seq_ratio_match.sv
// Ratio matcher: reports whether rate/ratio (truncated) lies in [LO_MHZ, HI_MHZ].
// Assumes rates in whole MHz; uses multiply bounds instead of a divider.
module seq_ratio_match
    import usb_seq_pkg::*;
#(
    parameter int RATE_W = 14,
    parameter int LO_MHZ = 150,
    parameter int HI_MHZ = 300
) (
    input  logic [RATE_W-1:0] rate_i,
    input  logic [SEL_W-1:0]  code_i,
    output logic              hit_o
);
    logic [31:0] ratio;
    logic [31:0] rate_ext;
    logic [31:0] lo_bound;
    logic [31:0] hi_bound;

    // floor(rate/r) in [LO,HI] is equivalent to LO*r <= rate <= HI*r + r - 1.
    always_comb begin
        ratio    = 32'(ratio_of(code_i));
        rate_ext = 32'(rate_i);
        lo_bound = 32'(LO_MHZ) * ratio;
        hi_bound = 32'(HI_MHZ) * ratio + ratio - 32'd1;
        hit_o    = (rate_ext >= lo_bound) && (rate_ext <= hi_bound);
    end
endmodule

// File: rtl/seq_wait_timer.sv
// Wait timer: while run_i is high, pulses expire_o on the WAIT_CYC-th cycle.
// Assumes run_i stays high for a whole interval; restarts from zero each interval.
module seq_wait_timer #(
    parameter int WAIT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Counts cycles spent in a wait state and wraps at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!run_i)      cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && (cnt_q == LAST);

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/seq_port_io.sv
// Port I/O: captures port-power settings on latch_i and corrects pin polarities.
// Assumes latch_i pulses once per sequence; disabled control forces active-high.
module seq_port_io (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_i,
    input  logic en_cfg_i,
    input  logic pol_cfg_i,
    input  logic pp_req_i,
    input  logic oc_pol_high_i,
    input  logic oc_pin_i,
    output logic pp_pin_o,
    output logic oc_flag_o
);
    logic en_q;
    logic pol_high_q;

    // Holds the captured port-power enable and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            pol_high_q <= 1'b1;
        end else if (latch_i) begin
            en_q       <= en_cfg_i;
            pol_high_q <= en_cfg_i ? pol_cfg_i : 1'b1;
        end
    end

    // Drives the pin from the request at the captured polarity.
    always_comb begin
        pp_pin_o  = en_q && (pol_high_q ? pp_req_i : !pp_req_i);
        oc_flag_o = oc_pol_high_i ? oc_pin_i : !oc_pin_i;
    end

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> ($stable(en_q) && $stable(pol_high_q)));
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pp_pin_o);
endmodule

// File: rtl/usb_bringup_seq.sv
// Top: bring-up state machine for a dual-role USB controller.
// Assumes rate_mhz_i and port-power settings are stable from start until done/err;
// only rst_n leaves the DONE and ERR states.
module usb_bringup_seq
    import usb_seq_pkg::*;
#(
    parameter int RATE_W   = 14,
    parameter int WAIT_CYC = 10,
    parameter int LO_MHZ   = 150,
    parameter int HI_MHZ   = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_mhz_i,
    input  logic              pp_en_cfg_i,
    input  logic              pp_pol_high_i,
    input  logic              pp_req_i,
    input  logic              oc_pol_high_i,
    input  logic              oc_pin_i,
    output logic              phy_rst_o,
    output logic              core_rst_o,
    output logic              shim_rst_o,
    output logic              div_rst_o,
    output logic [2:0]        div_sel_o,
    output logic              hclk_en_o,
    output logic              hs_pwr_o,
    output logic              ss_pwr_o,
    output logic              ssc_en_o,
    output logic              ssp_ref_en_o,
    output logic              ifclk_en_o,
    output logic              mode_dev_o,
    output logic              pp_pin_o,
    output logic              oc_flag_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_RATIOS - 1);

    seq_state_t        state_q;
    logic [SEL_W-1:0]  code_q;
    logic              hit;
    logic              wait_run;
    logic              wait_done;
    logic              pp_latch;

    seq_ratio_match #(.RATE_W(RATE_W), .LO_MHZ(LO_MHZ), .HI_MHZ(HI_MHZ)) u_match (
        .rate_i (rate_mhz_i),
        .code_i (code_q),
        .hit_o  (hit)
    );

    assign wait_run = (state_q == ST_WAIT1) || (state_q == ST_WAIT2) || (state_q == ST_WAIT3);
    assign pp_latch = (state_q == ST_PPC);

    seq_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (wait_run),
        .expire_o (wait_done)
    );

    seq_port_io u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .latch_i       (pp_latch),
        .en_cfg_i      (pp_en_cfg_i),
        .pol_cfg_i     (pp_pol_high_i),
        .pp_req_i      (pp_req_i),
        .oc_pol_high_i (oc_pol_high_i),
        .oc_pin_i      (oc_pin_i),
        .pp_pin_o      (pp_pin_o),
        .oc_flag_o     (oc_flag_o)
    );

    // Steps the bring-up order; each state performs its action on leaving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            code_q       <= '0;
            phy_rst_o    <= 1'b1;
            core_rst_o   <= 1'b1;
            shim_rst_o   <= 1'b1;
            div_rst_o    <= 1'b0;
            div_sel_o    <= '0;
            hclk_en_o    <= 1'b0;
            hs_pwr_o     <= 1'b0;
            ss_pwr_o     <= 1'b0;
            ssc_en_o     <= 1'b0;
            ssp_ref_en_o <= 1'b0;
            ifclk_en_o   <= 1'b0;
            mode_dev_o   <= 1'b1;
            done_o       <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE:    if (start_i) state_q <= ST_RSTALL;
                ST_RSTALL: begin
                    phy_rst_o  <= 1'b1;
                    core_rst_o <= 1'b1;
                    shim_rst_o <= 1'b1;
                    state_q    <= ST_DIVRST;
                end
                ST_DIVRST: begin
                    div_rst_o <= 1'b1;
                    code_q    <= '0;
                    state_q   <= ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (hit) begin
                        div_sel_o <= 3'(code_q);
                        hclk_en_o <= 1'b1;
                        state_q   <= ST_DIVREL;
                    end else if (code_q == LAST_CODE) begin
                        err_o   <= 1'b1;
                        state_q <= ST_ERR;
                    end else begin
                        code_q <= code_q + 1'b1;
                    end
                end
                ST_DIVREL: begin
                    div_rst_o <= 1'b0;
                    state_q   <= ST_PWR;
                end
                ST_PWR: begin
                    hs_pwr_o     <= 1'b1;
                    ss_pwr_o     <= 1'b1;
                    ssc_en_o     <= 1'b1;
                    ssp_ref_en_o <= 1'b1;
                    state_q      <= ST_WAIT1;
                end
                ST_WAIT1:   if (wait_done) state_q <= ST_SHIMREL;
                ST_SHIMREL: begin
                    shim_rst_o <= 1'b0;
                    state_q    <= ST_WAIT2;
                end
                ST_WAIT2:   if (wait_done) state_q <= ST_PPC;
                ST_PPC:     state_q <= ST_COREREL;
                ST_COREREL: begin
                    core_rst_o <= 1'b0;
                    state_q    <= ST_WAIT3;
                end
                ST_WAIT3:   if (wait_done) state_q <= ST_FIN;
                ST_FIN: begin
                    ifclk_en_o <= 1'b1;
                    mode_dev_o <= 1'b0;
                    state_q    <= ST_PHYREL;
                end
                ST_PHYREL: begin
                    phy_rst_o <= 1'b0;
                    done_o    <= 1'b1;
                    state_q   <= ST_DONE;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    p_phy_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst_o) |-> (!core_rst_o && !shim_rst_o && ifclk_en_o && !mode_dev_o));
    p_shim_before_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> !shim_rst_o);
    p_pick_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hclk_en_o) |-> div_rst_o);
    p_pwr_after_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_pwr_o) |-> (!div_rst_o && hclk_en_o));
    p_err_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (phy_rst_o && core_rst_o && shim_rst_o && !done_o));
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(div_sel_o) && !phy_rst_o));
endmodule

// File: tb/usb_bringup_seq_bench.sv
// Bench: behavioural timeline model of the bring-up order, compared every cycle.
module usb_bringup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int RW         = 14;
    localparam int NEVER      = 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [RW-1:0] rate_mhz_i = '0;
    logic          pp_en_cfg_i = 1'b0;
    logic          pp_pol_high_i = 1'b0;
    logic          pp_req_i = 1'b0;
    logic          oc_pol_high_i = 1'b0;
    logic          oc_pin_i = 1'b0;
    logic          phy_rst_o, core_rst_o, shim_rst_o, div_rst_o;
    logic [2:0]    div_sel_o;
    logic          hclk_en_o, hs_pwr_o, ss_pwr_o, ssc_en_o, ssp_ref_en_o;
    logic          ifclk_en_o, mode_dev_o, pp_pin_o, oc_flag_o, done_o, err_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_bringup_seq #(.RATE_W(RW), .WAIT_CYC(W)) u_usb_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_mhz_i(rate_mhz_i),
        .pp_en_cfg_i(pp_en_cfg_i), .pp_pol_high_i(pp_pol_high_i), .pp_req_i(pp_req_i),
        .oc_pol_high_i(oc_pol_high_i), .oc_pin_i(oc_pin_i),
        .phy_rst_o(phy_rst_o), .core_rst_o(core_rst_o), .shim_rst_o(shim_rst_o),
        .div_rst_o(div_rst_o), .div_sel_o(div_sel_o), .hclk_en_o(hclk_en_o),
        .hs_pwr_o(hs_pwr_o), .ss_pwr_o(ss_pwr_o), .ssc_en_o(ssc_en_o),
        .ssp_ref_en_o(ssp_ref_en_o), .ifclk_en_o(ifclk_en_o), .mode_dev_o(mode_dev_o),
        .pp_pin_o(pp_pin_o), .oc_flag_o(oc_flag_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic int tb_ratio(input int i);
        int t[8] = '{1, 2, 4, 6, 8, 16, 24, 32};
        return t[i];
    endfunction

    // First table index whose truncated quotient is in the window, or -1.
    function automatic int first_fit(input int rate);
        for (int i = 0; i < 8; i++) begin
            int q = rate / tb_ratio(i);
            if (q >= 150 && q <= 300) return i;
        end
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compares every output against the timeline for n edges after start (n<0: idle).
    task automatic compare(input int n, input int k);
        int kk  = (k < 0) ? NEVER : k;
        int ppx;
        ppx = (n >= 7 + kk + 2*W && pp_en_cfg_i) ? (pp_pol_high_i ? pp_req_i : !pp_req_i) : 0;
        chk("R2", "div_rst",  div_rst_o,  (n >= 2 && n < 4 + kk) ? 1 : 0);
        chk("R3", "div_sel",  div_sel_o,  (n >= 3 + kk) ? kk : 0);
        chk("R3", "hclk_en",  hclk_en_o,  (n >= 3 + kk) ? 1 : 0);
        chk("R4", "hs_pwr",   hs_pwr_o,   (n >= 5 + kk) ? 1 : 0);
        chk("R4", "ss_pwr",   ss_pwr_o,   (n >= 5 + kk) ? 1 : 0);
        chk("R4", "ssc_en",   ssc_en_o,   (n >= 5 + kk) ? 1 : 0);
        chk("R4", "ssp_ref",  ssp_ref_en_o, (n >= 5 + kk) ? 1 : 0);
        chk("R5", "shim_rst", shim_rst_o, (n < 6 + kk + W) ? 1 : 0);
        chk("R5", "core_rst", core_rst_o, (n < 8 + kk + 2*W) ? 1 : 0);
        chk("R5", "ifclk_en", ifclk_en_o, (n >= 9 + kk + 3*W) ? 1 : 0);
        chk("R5", "mode_dev", mode_dev_o, (n < 9 + kk + 3*W) ? 1 : 0);
        chk("R5", "phy_rst",  phy_rst_o,  (n < 10 + kk + 3*W) ? 1 : 0);
        chk("R5", "done",     done_o,     (n >= 10 + kk + 3*W) ? 1 : 0);
        chk("R6", "err",      err_o,      (k < 0 && n >= 10) ? 1 : 0);
        chk("R8", "pp_pin",   pp_pin_o,   ppx);
        chk("R9", "oc_flag",  oc_flag_o,  oc_pol_high_i ? oc_pin_i : !oc_pin_i);
    endtask

    // One full run from reset; hold keeps start high throughout (R7).
    task automatic run_case(input int rate, input logic en, input logic pol, input logic req,
                            input logic ocp, input logic ocv, input logic hold);
        int k = first_fit(rate);
        int total = ((k < 0) ? 12 : 10 + k + 3*W) + 8;
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0;
        rate_mhz_i = RW'(rate); pp_en_cfg_i = en; pp_pol_high_i = pol; pp_req_i = req;
        oc_pol_high_i = ocp; oc_pin_i = ocv;
        @(negedge clk);
        compare(-1, k);  // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(-1, k);  // R1 after reset
        start_i = 1'b1;
        @(posedge clk);  // start edge, n = 0
        for (int n = 0; n <= total; n++) begin
            @(negedge clk);
            if (!hold) start_i = 1'b0;
            compare(n, k);
        end
        // R7: a fresh pulse after done/err changes nothing
        start_i = 1'b1;
        for (int n = total + 1; n <= total + 6; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            compare(n, k);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        run_case(300,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R3 upper edge, ratio 1
        run_case(301,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R3 ratio 2, R8 active low
        run_case(602,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R3 301 rejects ratio 2
        run_case(5000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R8 disabled, ratio 24
        run_case(9000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1); // R7 start held, ratio 32
        run_case(100,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1); // R6 too slow
        run_case(9700, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R6 too fast
        run_case(1200, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R3 ratio 4 on exact 300
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule